// File: doc/BRIEF.md
# Packed Pixel Fetch and Unpacker

This block reads a frame of packed pixels out of byte-wide display memory and delivers it as a stream of pixel values, one per clock, in raster order from the top-left pixel. A pixel is 1, 2 or 4 bits deep. At one bit per pixel the pixel order inside a byte can be most-significant-bit first or least-significant-bit first. Each display line begins at a programmable distance (the line stride) from the start of the line before it, so a frame can sit inside a wider surface.

Software sets the configuration inputs and pulses `start`. The block samples the configuration and issues byte reads on a synchronous read port with a fixed one-cycle latency. It unpacks the returned bytes into 4-bit pixels on a valid/ready output, with a flag on the last pixel of each line and on the last pixel of the frame. The read side prefetches into a small byte queue, so the output runs without gaps while the consumer keeps ready high.

Top module: `packed_pixel_fetch`

## Requirements
- R1: With `cfg_depth` = 2'b00 and `cfg_lsb_first` = 0, the leftmost pixel of a byte is bit 7, the next is bit 6, down to bit 0, and the following byte holds the next eight pixels.
- R2: With `cfg_depth` = 2'b00 and `cfg_lsb_first` = 1, the leftmost pixel of a byte is bit 0, the next is bit 1, up to bit 7.
- R3: With `cfg_depth` = 2'b01 each byte holds four pixels, left to right in bits [7:6], [5:4], [3:2], [1:0]. `cfg_lsb_first` has no effect.
- R4: With `cfg_depth` = 2'b10 or 2'b11 each byte holds two pixels, the left one in bits [7:4] and the right one in bits [3:0]. `cfg_lsb_first` has no effect.
- R5: `pix_data` is 4 bits wide. At 1 and 2 bits per pixel the value is zero-extended at the top.
- R6: Line 0 starts at `cfg_base`, and line n+1 starts at line n's start plus `cfg_stride`. Within a line the bytes are read at consecutive addresses. Each frame reads exactly ceil(width*bpp/8) bytes per line, each once and in ascending order, and nothing else.
- R7: Pixels come out in raster order, exactly `cfg_width` per line and `cfg_height` lines. The unused slots of a partly filled last byte of a line are never emitted.
- R8: `pix_eol` is high on the last pixel of every line and only there. `pix_eof` is high on the last pixel of the frame and only there.
- R9: While `pix_valid` is high and `pix_ready` is low, `pix_valid`, `pix_data`, `pix_eol` and `pix_eof` hold their values. No pixel is lost or repeated.
- R10: With `pix_ready` held high, once the first pixel of a frame appears the whole frame comes out in width*height consecutive cycles, with no gaps.
- R11: Configuration is sampled on a `start` pulse while the block is idle. Changes to the configuration inputs and further `start` pulses have no effect until the end-of-frame pixel is accepted.
- R12: After reset, `pix_valid` and `mem_rd` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a frame (taken only when idle) |
| cfg_base | input | ADDR_W | Byte address of the top-left pixel's byte |
| cfg_stride | input | ADDR_W | Byte distance between starts of adjacent lines (at least one line's byte count) |
| cfg_width | input | DIM_W | Pixels per line, at least 1 |
| cfg_height | input | DIM_W | Lines per frame, at least 1 |
| cfg_depth | input | 2 | 00: 1 bpp, 01: 2 bpp, 10/11: 4 bpp |
| cfg_lsb_first | input | 1 | At 1 bpp, 1 selects bit 0 as the leftmost pixel |
| mem_rd | output | 1 | Read request |
| mem_addr | output | ADDR_W | Read byte address |
| mem_rdata | input | 8 | Read data, valid one cycle after the request |
| pix_valid | output | 1 | Pixel available |
| pix_ready | input | 1 | Consumer accepts the pixel |
| pix_data | output | 4 | Pixel value, zero-extended |
| pix_eol | output | 1 | Last pixel of a line |
| pix_eof | output | 1 | Last pixel of the frame |

## Verification
The hardest situation to reach is a byte queue that must refill every single cycle. This happens at one byte per pixel, for example 4 bpp with a width of one pixel, or at line ends where a partly used byte is dropped early. The read-to-data loop then has to keep up with no slack. Directed frames with one-pixel lines and ready held high push the block there and check for an unbroken output run. Random frames with random ready back-pressure cover stalls that arrive in the middle of a byte and on the flagged last pixels, while every read address is compared with the expected line-by-line walk.

// File: rtl/pfu_pkg.sv
package pfu_pkg;

  // Depth code: 0 -> 1 bpp, 1 -> 2 bpp, 2 and 3 -> 4 bpp.
  function automatic logic [1:0] bpp_shift(input logic [1:0] dcode);
    return (dcode == 2'd3) ? 2'd2 : dcode;
  endfunction

  // Index of the last pixel slot inside one byte.
  function automatic logic [2:0] last_slot(input logic [1:0] dcode);
    case (bpp_shift(dcode))
      2'd0:    return 3'd7;
      2'd1:    return 3'd3;
      default: return 3'd1;
    endcase
  endfunction

  // Select pixel slot 'slot' from a packed byte, zero-extended to 4 bits.
  function automatic logic [3:0] pick_pixel(input logic [7:0] b, input logic [2:0] slot,
                                            input logic [1:0] dcode, input logic lsb_first);
    logic [7:0] t;
    case (bpp_shift(dcode))
      2'd0: begin
        if (lsb_first) return {3'b000, b[slot]};
        t = b << slot;
        return {3'b000, t[7]};
      end
      2'd1: begin
        t = b << {slot[1:0], 1'b0};
        return {2'b00, t[7:6]};
      end
      default: return slot[0] ? b[3:0] : b[7:4];
    endcase
  endfunction

endpackage

// File: rtl/pfu_fetch.sv
module pfu_fetch #(
  parameter int ADDR_W     = 16,
  parameter int DIM_W      = 10,
  parameter int FIFO_DEPTH = 4,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1),
  localparam int BPL_W     = DIM_W + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] stride,
  input  logic [BPL_W-1:0]  bpl,
  input  logic [DIM_W-1:0]  height,
  input  logic [CNT_W-1:0]  fifo_cnt,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              data_vld
);

  logic              active;
  logic [ADDR_W-1:0] line_addr;
  logic [BPL_W-1:0]  byte_idx;
  logic [DIM_W-1:0]  line_cnt;
  logic [CNT_W+1:0]  occupancy;
  logic              issue;

  // Bytes stored plus reads still travelling through the request and data stages.
  assign occupancy = (CNT_W + 2)'(fifo_cnt) + (CNT_W + 2)'(mem_rd) + (CNT_W + 2)'(data_vld);
  assign issue     = active && (occupancy < (CNT_W + 2)'(FIFO_DEPTH));

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      line_addr <= '0;
      byte_idx  <= '0;
      line_cnt  <= '0;
      mem_rd    <= 1'b0;
      mem_addr  <= '0;
      data_vld  <= 1'b0;
    end else begin
      mem_rd   <= issue;
      data_vld <= mem_rd;
      if (issue) mem_addr <= line_addr + ADDR_W'(byte_idx);
      if (go) begin
        active    <= 1'b1;
        line_addr <= base;
        byte_idx  <= '0;
        line_cnt  <= '0;
      end else if (issue) begin
        if (byte_idx == bpl - 1'b1) begin
          byte_idx  <= '0;
          line_addr <= line_addr + stride;
          line_cnt  <= line_cnt + 1'b1;
          if (line_cnt == height - 1'b1) active <= 1'b0;
        end else begin
          byte_idx <= byte_idx + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/pfu_fifo.sv
module pfu_fifo #(
  parameter int DEPTH  = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [7:0]       din,
  input  logic             pop,
  output logic [7:0]       head,
  output logic [CNT_W-1:0] cnt
);

  logic [7:0]       store [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;

  assign head = store[rptr];

  always_ff @(posedge clk) begin
    if (push) store[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (push) wptr <= (wptr == PTR_W'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == PTR_W'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      cnt <= cnt + CNT_W'(push) - CNT_W'(pop);
    end
  end

endmodule

// File: rtl/pfu_unpack.sv
module pfu_unpack #(
  parameter int DIM_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [1:0]       dcode,
  input  logic             lsb_first,
  input  logic [DIM_W-1:0] width,
  input  logic [DIM_W-1:0] height,
  input  logic [7:0]       head,
  input  logic             nempty,
  output logic             pop,
  output logic             o_valid,
  input  logic             o_ready,
  output logic [3:0]       o_pix,
  output logic             o_eol,
  output logic             o_eof
);
  import pfu_pkg::*;

  logic             have, fin;
  logic [7:0]       sreg;
  logic [2:0]       slot;
  logic [DIM_W-1:0] x, y;
  logic             adv, emit, last_x, byte_done;
  logic [7:0]       cur_b;
  logic [2:0]       cur_s;

  assign adv       = !o_valid || o_ready;
  assign emit      = adv && !fin && (have || nempty);
  assign cur_b     = have ? sreg : head;
  assign cur_s     = have ? slot : 3'd0;
  assign last_x    = (x == width - 1'b1);
  assign byte_done = last_x || (cur_s == last_slot(dcode));
  assign pop       = emit && !have;

  always_ff @(posedge clk) begin
    if (rst) begin
      have    <= 1'b0;
      fin     <= 1'b1;
      sreg    <= '0;
      slot    <= '0;
      x       <= '0;
      y       <= '0;
      o_valid <= 1'b0;
      o_pix   <= '0;
      o_eol   <= 1'b0;
      o_eof   <= 1'b0;
    end else if (go) begin
      have <= 1'b0;
      fin  <= 1'b0;
      x    <= '0;
      y    <= '0;
    end else if (emit) begin
      o_valid <= 1'b1;
      o_pix   <= pick_pixel(cur_b, cur_s, dcode, lsb_first);
      o_eol   <= last_x;
      o_eof   <= last_x && (y == height - 1'b1);
      if (last_x && (y == height - 1'b1)) fin <= 1'b1;
      have <= !byte_done;
      sreg <= cur_b;
      slot <= cur_s + 1'b1;
      x    <= last_x ? '0 : x + 1'b1;
      if (last_x) y <= y + 1'b1;
    end else if (adv) begin
      o_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/packed_pixel_fetch.sv
module packed_pixel_fetch #(
  parameter int ADDR_W     = 16,
  parameter int DIM_W      = 10,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W-1:0] cfg_stride,
  input  logic [DIM_W-1:0]  cfg_width,
  input  logic [DIM_W-1:0]  cfg_height,
  input  logic [1:0]        cfg_depth,
  input  logic              cfg_lsb_first,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic              pix_valid,
  input  logic              pix_ready,
  output logic [3:0]        pix_data,
  output logic              pix_eol,
  output logic              pix_eof
);
  import pfu_pkg::*;

  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam int BPL_W = DIM_W + 3;

  logic              busy, go_q;
  logic [ADDR_W-1:0] base_q, stride_q;
  logic [DIM_W-1:0]  width_q, height_q;
  logic [1:0]        depth_q;
  logic              lsb_q;
  logic [BPL_W-1:0]  bpl;
  logic [CNT_W-1:0]  fifo_cnt;
  logic [7:0]        fifo_head;
  logic              fifo_pop, data_vld;

  // Bytes per line: ceil(width * bpp / 8).
  assign bpl = ((BPL_W'(width_q) << bpp_shift(depth_q)) + BPL_W'(7)) >> 3;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      go_q     <= 1'b0;
      base_q   <= '0;
      stride_q <= '0;
      width_q  <= '0;
      height_q <= '0;
      depth_q  <= '0;
      lsb_q    <= 1'b0;
    end else begin
      go_q <= start && !busy;
      if (start && !busy) begin
        busy     <= 1'b1;
        base_q   <= cfg_base;
        stride_q <= cfg_stride;
        width_q  <= cfg_width;
        height_q <= cfg_height;
        depth_q  <= cfg_depth;
        lsb_q    <= cfg_lsb_first;
      end else if (pix_valid && pix_ready && pix_eof) begin
        busy <= 1'b0;
      end
    end
  end

  pfu_fetch #(.ADDR_W(ADDR_W), .DIM_W(DIM_W), .FIFO_DEPTH(FIFO_DEPTH)) u_fetch (
    .clk(clk), .rst(rst), .go(go_q), .base(base_q), .stride(stride_q), .bpl(bpl),
    .height(height_q), .fifo_cnt(fifo_cnt), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .data_vld(data_vld)
  );

  pfu_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(data_vld), .din(mem_rdata), .pop(fifo_pop),
    .head(fifo_head), .cnt(fifo_cnt)
  );

  pfu_unpack #(.DIM_W(DIM_W)) u_unpack (
    .clk(clk), .rst(rst), .go(go_q), .dcode(depth_q), .lsb_first(lsb_q),
    .width(width_q), .height(height_q), .head(fifo_head), .nempty(fifo_cnt != '0),
    .pop(fifo_pop), .o_valid(pix_valid), .o_ready(pix_ready), .o_pix(pix_data),
    .o_eol(pix_eol), .o_eof(pix_eof)
  );

endmodule

// File: rtl/pfu_checker.sv
module pfu_checker #(
  parameter int FIFO_DEPTH = 4,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             pix_valid,
  input logic             pix_ready,
  input logic [3:0]       pix_data,
  input logic             pix_eol,
  input logic             pix_eof,
  input logic             mem_rd,
  input logic             busy,
  input logic [1:0]       depth_q,
  input logic [CNT_W-1:0] fifo_cnt
);

  assert_hold_on_stall_R9: assert property (@(posedge clk) disable iff (rst)
    pix_valid && !pix_ready |=> pix_valid && $stable(pix_data) && $stable(pix_eol) && $stable(pix_eof));

  assert_eof_is_eol_R8: assert property (@(posedge clk) disable iff (rst)
    pix_valid && pix_eof |-> pix_eol);

  assert_zero_ext_1bpp_R5: assert property (@(posedge clk) disable iff (rst)
    pix_valid && depth_q == 2'd0 |-> pix_data[3:1] == 3'b000);

  assert_zero_ext_2bpp_R5: assert property (@(posedge clk) disable iff (rst)
    pix_valid && depth_q == 2'd1 |-> pix_data[3:2] == 2'b00);

  assert_no_read_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !busy && !$past(busy) |-> !mem_rd);

  assert_queue_bound_R10: assert property (@(posedge clk) disable iff (rst)
    fifo_cnt <= CNT_W'(FIFO_DEPTH));

  assert_idle_after_reset_R12: assert property (@(posedge clk)
    $past(rst) |-> !pix_valid && !mem_rd);

endmodule

bind packed_pixel_fetch pfu_checker #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data),
  .pix_eol(pix_eol), .pix_eof(pix_eof), .mem_rd(mem_rd), .busy(busy), .depth_q(depth_q),
  .fifo_cnt(fifo_cnt)
);

// File: tb/packed_pixel_fetch_tb.sv
`timescale 1ns/1ps
module packed_pixel_fetch_tb;
  localparam int ADDR_W = 16;
  localparam int DIM_W  = 10;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [ADDR_W-1:0] cfg_base = '0, cfg_stride = '0;
  logic [DIM_W-1:0]  cfg_width = '0, cfg_height = '0;
  logic [1:0]        cfg_depth = '0;
  logic              cfg_lsb_first = 1'b0;
  logic              mem_rd;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0]        mem_rdata = '0;
  logic              pix_valid, pix_eol, pix_eof;
  logic              pix_ready = 1'b0;
  logic [3:0]        pix_data;

  logic [7:0] mem [4096];
  int checks = 0, errors = 0;

  // Frame seen by the bench (held from start to end of frame).
  int fb_base, fb_stride, fb_w, fb_h, fb_d, fb_lsb, fb_bpl;
  int rd_x, rd_y;
  bit rd_track = 0;

  always #2 clk = ~clk;

  packed_pixel_fetch #(.ADDR_W(ADDR_W), .DIM_W(DIM_W), .FIFO_DEPTH(4)) u_dut (
    .clk(clk), .rst(rst), .start(start), .cfg_base(cfg_base), .cfg_stride(cfg_stride),
    .cfg_width(cfg_width), .cfg_height(cfg_height), .cfg_depth(cfg_depth),
    .cfg_lsb_first(cfg_lsb_first), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_data(pix_data), .pix_eol(pix_eol), .pix_eof(pix_eof)
  );

  always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[11:0]];

  function automatic int bpp_of(int d);
    return (d == 0) ? 1 : (d == 1) ? 2 : 4;
  endfunction

  function automatic int exp_pix(int x, int y);
    int bpp, boff, a, k;
    logic [7:0] b;
    bpp  = bpp_of(fb_d);
    boff = x * bpp;
    a    = fb_base + y * fb_stride + boff / 8;
    b    = mem[a % 4096];
    k    = boff % 8;
    if (fb_d == 0 && fb_lsb != 0) return int'(b[k]);
    return (int'(b) >> (8 - bpp - k)) & ((1 << bpp) - 1);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // R6: every read must be the next byte of the expected line walk.
  always @(posedge clk) begin
    if (!rst && mem_rd) begin
      int ea;
      ea = fb_base + rd_y * fb_stride + rd_x;
      check(rd_track && rd_y < fb_h && int'(mem_addr) == ea, "R6", "read address",
            int'(mem_addr), ea);
      if (rd_x == fb_bpl - 1) begin rd_x = 0; rd_y++; end
      else rd_x++;
    end
  end

  task automatic run_frame(int base, int stride, int w, int h, int d, int lsb,
                           bit rdy_high, bit disturb, string req);
    int ex = 0, ey = 0, cyc = 0, first = -1, last = 0;
    bit done = 0;
    fb_base = base; fb_stride = stride; fb_w = w; fb_h = h; fb_d = d; fb_lsb = lsb;
    fb_bpl = (w * bpp_of(d) + 7) / 8;
    rd_x = 0; rd_y = 0; rd_track = 1;
    @(negedge clk);
    cfg_base = ADDR_W'(base); cfg_stride = ADDR_W'(stride);
    cfg_width = DIM_W'(w); cfg_height = DIM_W'(h);
    cfg_depth = 2'(d); cfg_lsb_first = lsb[0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      pix_ready = rdy_high ? 1'b1 : (($urandom % 10) < 6);
      if (disturb && (cyc == 3 || cyc == 9)) begin
        // R11: new settings and a start pulse mid-frame must be ignored.
        cfg_base = ADDR_W'(base + 100); cfg_width = DIM_W'(w + 3);
        cfg_height = DIM_W'(h + 1); cfg_depth = 2'(d ^ 1); cfg_lsb_first = ~lsb[0];
        start = 1'b1;
      end else begin
        start = 1'b0;
      end
      #1;
      if (pix_valid && pix_ready) begin
        int ep;
        bit eol, eof;
        ep  = exp_pix(ex, ey);
        eol = (ex == w - 1);
        eof = eol && (ey == h - 1);
        check(int'(pix_data) == ep, req, "pixel value", int'(pix_data), ep);
        check(pix_eol == eol && pix_eof == eof, "R8", "line/frame flags",
              {pix_eol, pix_eof}, {eol, eof});
        if (first < 0) first = cyc;
        last = cyc;
        if (eol) begin ex = 0; ey++; end
        else ex++;
        if (pix_eof || ey >= h) done = 1;
      end
    end
    start = 1'b0;
    check(done, "R7", "frame completed", ey, h);
    check(ex == 0 && ey == h, "R7", "pixel count lines", ey, h);
    repeat (4) @(negedge clk);
    check(rd_y == h && rd_x == 0, "R6", "lines read", rd_y, h);
    check(!pix_valid, "R7", "no extra pixel", int'(pix_valid), 0);
    if (rdy_high) check(last - first + 1 == w * h, "R10", "gapless run cycles",
                        last - first + 1, w * h);
    rd_track = 0;
  endtask

  initial begin
    #(4ns * 190000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1f2e3d));
    for (int i = 0; i < 4096; i++) mem[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    #1;
    check(!pix_valid && !mem_rd, "R12", "outputs during reset", {pix_valid, mem_rd}, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check(!pix_valid && !mem_rd, "R12", "idle after reset", {pix_valid, mem_rd}, 0);

    run_frame(16, 4, 13, 3, 0, 0, 1'b1, 1'b0, "R1");
    run_frame(200, 2, 10, 2, 0, 1, 1'b0, 1'b0, "R2");
    run_frame(300, 3, 7, 3, 1, 1, 1'b0, 1'b0, "R3");
    run_frame(400, 5, 5, 4, 2, 1, 1'b1, 1'b0, "R4");
    run_frame(450, 1, 1, 6, 2, 0, 1'b1, 1'b0, "R10");
    run_frame(500, 1, 1, 6, 0, 0, 1'b1, 1'b0, "R10");
    run_frame(520, 9, 6, 3, 3, 0, 1'b0, 1'b0, "R4");
    run_frame(600, 3, 9, 3, 1, 0, 1'b1, 1'b0, "R5");
    run_frame(700, 6, 11, 4, 0, 0, 1'b0, 1'b1, "R11");
    for (int n = 0; n < 14; n++) begin
      int d, w, h, bpl;
      d   = $urandom % 4;
      w   = 1 + $urandom % 40;
      h   = 1 + $urandom % 6;
      bpl = (w * bpp_of(d) + 7) / 8;
      run_frame($urandom % 512, bpl + $urandom % 5, w, h, d, $urandom % 2,
                n[0], 1'b0, "R7");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule